// File: doc/BRIEF.md
# SPI Slave Port with Write-Collision Detection

This block is the receive-and-transmit half of a serial peripheral port. It always acts as the slave. An external master drives the serial clock, the data-in line and an active-low select line. The block shifts one 8-bit character per exchange, most significant bit first, in both directions. A CPU reaches it through three byte-wide registers: a control register, a status register and a data register. Writing the data register preloads the next outgoing character. Reading the data register returns the last character received.

All three serial inputs are asynchronous. Each one passes through a two-flop synchronizer into the system clock domain, and clock and select edges are found there. The serial clock must therefore run at no more than a quarter of the system clock. A five-state machine tracks each character:

- **OFF**: the port is disabled or master-select is set.
- **IDLE**: select is high, or the block is waiting for a fresh select fall in phase 0.
- **READY**: phase 1, select is low, and no character is in flight.
- **ACTIVE**: a character is shifting.
- **SPENT**: phase 0, the character is finished, and the block waits for select to go high.

The transitions are:

- OFF→IDLE once the inputs have settled and the port is enabled in slave mode.
- IDLE→READY when select is low in phase 1.
- IDLE→ACTIVE on a select fall in phase 0.
- READY→ACTIVE on the leading clock edge.
- ACTIVE→READY in phase 1, or ACTIVE→SPENT in phase 0, on the eighth sampling edge.
- READY, ACTIVE or SPENT →IDLE when select rises.
- Any state →OFF when the port is disabled or master-select is set.

A CPU write to the data register while a character is ACTIVE raises the collision flag. It leaves the transmit buffer untouched. A constant serial clock level never counts as activity, so the levels the pins hold at reset cannot raise the flag.

Top module: `spi_tgt_port`

## Requirements
- R1: After reset, the control register reads 0x04, the status register reads 0x00, `miso_oe_o` is 0 and `irq_o` is 0. In the control register, bit 7 is the enable, bit 5 is master-select, bit 3 is clock polarity, bit 2 is clock phase and bits 1:0 are the rate bits.
- R2: The register addresses are 0 for control, 1 for status and 2 for data. Status bit 7 is transfer-complete, status bit 6 is write-collision, and the other status bits read 0. Control writes read back unchanged, and the rate bits have no effect on slave transfers.
- R3: In all four polarity/phase modes, the master receives the preloaded character and the data register returns the character shifted in, both MSB first. Transfer-complete sets after the eighth sampled bit. The sampling edge is the leading clock edge in phase 0 and the trailing edge in phase 1. The leading edge is the rising edge when polarity is 0 and the falling edge when polarity is 1.
- R4: In phase 0, a select fall starts a character and places its MSB on `miso_o` before any clock edge. After eight bits, further clock edges do nothing until select has gone high and then low again.
- R5: In phase 1, select may stay low across several characters. Each character starts on a leading clock edge and ends after eight trailing edges, and the first leading edge presents the MSB.
- R6: A data-register write while a character is ACTIVE sets the write-collision flag and leaves the transmit buffer unchanged. A data-register write outside a character does not set the flag.
- R7: After reset, with select low and the serial clock held high, enabling the port in phase 1 and writing the data register leaves the write-collision flag clear.
- R8: While master-select is 1, the port stays OFF and `miso_oe_o` is 0. If master-select is set together with polarity and phase, and then cleared before the first data access, the write-collision flag stays clear and the written character is transmitted.
- R9: Both flags clear only when a data-register access follows a status read that saw a flag set. A data access without such a status read leaves both flags set.
- R10: `miso_oe_o` is 0 while select is high or the port is disabled. Select rising mid-character abandons it, and the next character starts again from its MSB.
- R11: `irq_o` equals the transfer-complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | Write qualifier |
| cpu_rd | input | 1 | Read qualifier (side effects on status and data reads) |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| irq_o | output | 1 | Level interrupt, transfer complete |

## Verification
The shift path is exercised with characters sent in all four polarity/phase modes. The pairs are chosen with alternating, all-zero, all-one and single-bit patterns, so that a bit-order error, an edge-choice error or a stuck bit shows up in one direction or the other. Select is held low across back-to-back characters in phase 1, and kept low past the eighth bit in phase 0. These two cases separate the counted character boundary from the select-framed one. Partial characters, a CPU write in the middle of a character, and the reset-level pin condition separate a true in-flight character from a static clock level.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_READY,
        ST_ACTIVE,
        ST_SPENT
    } tgt_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int C_EN   = 7;
    localparam int C_HOST = 5;
    localparam int C_CPOL = 3;
    localparam int C_CPHA = 2;

    localparam int S_DONE = 7;
    localparam int S_WCOL = 6;

    localparam logic [7:0] CTRL_RST = 8'h04;

    localparam int PIN_SCK  = 0;
    localparam int PIN_MOSI = 1;
    localparam int PIN_SSN  = 2;
    localparam int PIN_CNT  = 3;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic         ok
);
    // One extra cycle so a downstream previous-value register is also valid.
    localparam int WARM = STAGES + 1;
    localparam int CNTW = $clog2(WARM + 1);

    logic [CNTW-1:0] warm_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pin
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= (chain_q << 1) | STAGES'(din[g]);
            end
            assign lvl[g] = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        warm_q <= '0;
        else if (warm_q != CNTW'(WARM))    warm_q <= warm_q + 1'b1;
    end

    assign ok = (warm_q == CNTW'(WARM));

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
    import spi_tgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_sel,
    input  logic         cpu_wr,
    input  logic         cpu_rd,
    input  logic [1:0]   cpu_addr,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic         in_char,
    input  logic         rx_load,
    input  logic [W-1:0] rx_word,
    output logic [7:0]   ctrl_q,
    output logic [W-1:0] tx_buf_q,
    output logic         done_q,
    output logic         wcol_q
);
    logic [W-1:0] rx_buf_q;
    logic         armed_q;
    logic         ctrl_wr, stat_rd, data_wr, data_acc, flag_clr;
    logic [7:0]   stat_byte;

    assign ctrl_wr  = cpu_sel && cpu_wr && (cpu_addr == A_CTRL);
    assign stat_rd  = cpu_sel && cpu_rd && (cpu_addr == A_STAT);
    assign data_wr  = cpu_sel && cpu_wr && (cpu_addr == A_DATA);
    assign data_acc = cpu_sel && (cpu_wr || cpu_rd) && (cpu_addr == A_DATA);
    assign flag_clr = data_acc && armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST;
            tx_buf_q <= '0;
            rx_buf_q <= '0;
            armed_q  <= 1'b0;
            done_q   <= 1'b0;
            wcol_q   <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= cpu_wdata[7:0];
            if (data_wr && !in_char)
                tx_buf_q <= cpu_wdata;
            if (rx_load)
                rx_buf_q <= rx_word;
            if (stat_rd && (done_q || wcol_q))
                armed_q <= 1'b1;
            else if (data_acc)
                armed_q <= 1'b0;
            done_q <= rx_load || (done_q && !flag_clr);
            wcol_q <= (data_wr && in_char) || (wcol_q && !flag_clr);
        end
    end

    always_comb begin
        stat_byte         = '0;
        stat_byte[S_DONE] = done_q;
        stat_byte[S_WCOL] = wcol_q;
    end

    always_comb begin
        case (cpu_addr)
            A_CTRL:  cpu_rdata = W'(ctrl_q);
            A_STAT:  cpu_rdata = W'(stat_byte);
            A_DATA:  cpu_rdata = rx_buf_q;
            default: cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_tgt_fsm.sv
module spi_tgt_fsm
    import spi_tgt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_ok,
    input  logic         en,
    input  logic         host,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         sck_s,
    input  logic         mosi_s,
    input  logic         ssn_s,
    input  logic [W-1:0] tx_buf,
    output tgt_state_e   state_q,
    output logic         miso,
    output logic         miso_oe,
    output logic         rx_load,
    output logic [W-1:0] rx_word
);
    localparam int             CW   = $clog2(W);
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    tgt_state_e     state_d;
    logic [W-1:0]   shreg_q;
    logic [CW-1:0]  cnt_q;
    logic           pend_q;
    logic           sck_prev_q, ssn_prev_q;
    logic           go, ss_lo, ss_fall, sck_rise, sck_fall;
    logic           lead, trail, samp, shft, last_bit, load;

    // Edge detection in the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            ssn_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            ssn_prev_q <= ssn_s;
        end
    end

    assign go       = sync_ok && en && !host;
    assign ss_lo    = !ssn_s;
    assign ss_fall  = sync_ok && ssn_prev_q && !ssn_s;
    assign sck_rise = sync_ok && !sck_prev_q && sck_s;
    assign sck_fall = sync_ok && sck_prev_q && !sck_s;
    assign lead     = cpol ? sck_fall : sck_rise;
    assign trail    = cpol ? sck_rise : sck_fall;
    assign samp     = cpha ? trail : lead;
    assign shft     = cpha ? lead : trail;
    assign last_bit = (cnt_q == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_IDLE;
                ST_IDLE: begin
                    if (ss_lo && cpha)         state_d = ST_READY;
                    else if (ss_fall && !cpha) state_d = ST_ACTIVE;
                end
                ST_READY: begin
                    if (!ss_lo)                state_d = ST_IDLE;
                    else if (lead)             state_d = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!ss_lo)                state_d = ST_IDLE;
                    else if (samp && last_bit) state_d = cpha ? ST_READY : ST_SPENT;
                end
                ST_SPENT: begin
                    if (!ss_lo)                state_d = ST_IDLE;
                end
                default:                       state_d = ST_OFF;
            endcase
        end
    end

    assign load = (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE);

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else if (load) begin
            shreg_q <= tx_buf;
            cnt_q   <= '0;
        end else if (state_q == ST_ACTIVE && go && ss_lo) begin
            if (samp) begin
                pend_q <= mosi_s;
                cnt_q  <= last_bit ? '0 : cnt_q + 1'b1;
            end
            if (shft)
                shreg_q <= {shreg_q[W-2:0], pend_q};
        end else if (state_q != ST_ACTIVE) begin
            cnt_q <= '0;
        end
    end

    // Outputs
    assign rx_load = (state_q == ST_ACTIVE) && go && ss_lo && samp && last_bit;
    assign rx_word = {shreg_q[W-2:0], mosi_s};
    assign miso    = shreg_q[W-1];
    assign miso_oe = (state_q == ST_READY) || (state_q == ST_ACTIVE) ||
                     (state_q == ST_SPENT);

endmodule

// File: rtl/spi_tgt_port.sv
module spi_tgt_port
    import spi_tgt_pkg::*;
#(
    parameter int CHAR_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_sel,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [1:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       ss_n_i,
    output logic       miso_o,
    output logic       miso_oe_o,
    output logic       irq_o
);
    logic [PIN_CNT-1:0]   pins, pins_s;
    logic                 sync_ok;
    logic [7:0]           ctrl_q;
    logic [CHAR_BITS-1:0] tx_buf_q, rx_word;
    logic                 done_q, wcol_q, rx_load, in_char;
    tgt_state_e           fsm_state;

    assign pins[PIN_SCK]  = sck_i;
    assign pins[PIN_MOSI] = mosi_i;
    assign pins[PIN_SSN]  = ss_n_i;

    spi_tgt_sync #(.N(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .lvl   (pins_s),
        .ok    (sync_ok)
    );

    assign in_char = (fsm_state == ST_ACTIVE);

    spi_tgt_regs #(.W(CHAR_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .in_char   (in_char),
        .rx_load   (rx_load),
        .rx_word   (rx_word),
        .ctrl_q    (ctrl_q),
        .tx_buf_q  (tx_buf_q),
        .done_q    (done_q),
        .wcol_q    (wcol_q)
    );

    spi_tgt_fsm #(.W(CHAR_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_ok (sync_ok),
        .en      (ctrl_q[C_EN]),
        .host    (ctrl_q[C_HOST]),
        .cpol    (ctrl_q[C_CPOL]),
        .cpha    (ctrl_q[C_CPHA]),
        .sck_s   (pins_s[PIN_SCK]),
        .mosi_s  (pins_s[PIN_MOSI]),
        .ssn_s   (pins_s[PIN_SSN]),
        .tx_buf  (tx_buf_q),
        .state_q (fsm_state),
        .miso    (miso_o),
        .miso_oe (miso_oe_o),
        .rx_load (rx_load),
        .rx_word (rx_word)
    );

    assign irq_o = done_q;

endmodule

// File: rtl/spi_tgt_checker.sv
module spi_tgt_checker
    import spi_tgt_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cpu_sel,
    input logic         cpu_wr,
    input logic [1:0]   cpu_addr,
    input tgt_state_e   state,
    input logic         done,
    input logic         wcol,
    input logic [W-1:0] tx_buf,
    input logic         miso_oe,
    input logic         ss_hi,
    input logic         en,
    input logic         host
);
    logic data_wr;
    assign data_wr = cpu_sel && cpu_wr && (cpu_addr == A_DATA);

    // R6: write during a character raises the collision flag
    assert_wcol_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == ST_ACTIVE) |=> wcol);

    // R6: write during a character leaves the transmit buffer alone
    assert_tx_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == ST_ACTIVE) |=> $stable(tx_buf));

    // R7: the collision flag only ever rises out of an active character
    assert_wcol_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> ($past(state) == ST_ACTIVE));

    // R3: completion only follows an active character
    assert_done_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == ST_ACTIVE));

    // R10: output driver released when deselected or disabled
    assert_oe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_hi || !en) |=> !miso_oe);

    // R8: master-select keeps the port off
    assert_host_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host |=> (state == ST_OFF));

endmodule

bind spi_tgt_port spi_tgt_checker #(.W(CHAR_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_sel  (cpu_sel),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .state    (fsm_state),
    .done     (done_q),
    .wcol     (wcol_q),
    .tx_buf   (tx_buf_q),
    .miso_oe  (miso_oe_o),
    .ss_hi    (pins_s[PIN_SSN]),
    .en       (ctrl_q[C_EN]),
    .host     (ctrl_q[C_HOST])
);

// File: tb/tb_spi_tgt_port.sv
module tb_spi_tgt_port;
    import spi_tgt_pkg::*;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       sck = 1'b1, mosi = 1'b0, ss_n = 1'b0;
    logic       miso, miso_oe, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_tgt_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .sck_i     (sck),
        .mosi_i    (mosi),
        .ss_n_i    (ss_n),
        .miso_o    (miso),
        .miso_oe_o (miso_oe),
        .irq_o     (irq)
    );

    // {cpol, cpha, rate[1:0], slave tx, master tx}
    localparam logic [19:0] VEC [6] = '{
        {1'b0, 1'b0, 2'b00, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 2'b01, 8'h5A, 8'hC3},
        {1'b1, 1'b0, 2'b10, 8'hF0, 8'h0F},
        {1'b1, 1'b1, 2'b11, 8'h81, 8'h7E},
        {1'b0, 1'b0, 2'b00, 8'h00, 8'hFF},
        {1'b1, 1'b1, 2'b00, 8'hFF, 8'h01}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] t;
        cpu_read(A_STAT, t);
        cpu_read(A_DATA, t);
    endtask

    task automatic xfer(input logic cpol, input logic cpha, input logic [7:0] mo,
                        input bit drop, input bit raise, input int nbits,
                        input int collide_at, input logic [7:0] cval,
                        output logic [7:0] mi);
        mi = 8'h00;
        sck = cpol;
        tick(H);
        if (drop) begin
            ss_n = 1'b0;
            tick(H);
        end
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (!cpha) begin
                mosi = mo[i];
                tick(H);
                mi[i] = miso;
                sck = ~cpol;
                if (collide_at == i) cpu_write(A_DATA, cval);
                tick(H);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mo[i];
                tick(H);
                mi[i] = miso;
                if (collide_at == i) cpu_write(A_DATA, cval);
                sck = cpol;
                tick(H);
            end
        end
        tick(H);
        if (raise) begin
            ss_n = 1'b1;
            tick(H);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, mi;
        // Reset with select low and the clock pin high
        tick(3);
        rst_n = 1'b1;
        tick(6);

        // R1: reset state
        cpu_read(A_CTRL, rd); chk("R1 ctrl reset", rd, 8'h04);
        cpu_read(A_STAT, rd); chk("R1 status reset", rd, 8'h00);
        chk("R1 miso_oe reset", miso_oe, 1'b0);
        chk("R1 irq reset", irq, 1'b0);

        // R7: first data write with select low, clock high, phase 1
        cpu_write(A_CTRL, 8'h84);
        tick(6);
        cpu_write(A_DATA, 8'h5A);
        tick(2);
        cpu_read(A_STAT, rd); chk("R7 no collision at reset levels", rd, 8'h00);
        chk("R10 miso_oe with select low", miso_oe, 1'b1);
        // R5: single slave, select never raised before the character
        xfer(1'b0, 1'b1, 8'h96, 1'b0, 1'b1, 8, -1, 8'h00, mi);
        chk("R5 tx with permanent select", mi, 8'h5A);
        cpu_read(A_STAT, rd); chk("R5 done after character", rd, 8'h80);
        cpu_read(A_DATA, rd); chk("R5 rx with permanent select", rd, 8'h96);
        chk("R10 miso_oe with select high", miso_oe, 1'b0);

        // R8: master-select written with polarity/phase, then cleared
        ss_n = 1'b0;
        cpu_write(A_CTRL, 8'h24);
        tick(6);
        chk("R8 miso_oe off under master-select", miso_oe, 1'b0);
        cpu_write(A_DATA, 8'h33);
        cpu_write(A_CTRL, 8'h84);
        tick(6);
        cpu_read(A_STAT, rd); chk("R8 no collision after procedure", rd, 8'h00);
        xfer(1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8, -1, 8'h00, mi);
        chk("R8 written character sent", mi, 8'h33);
        clear_flags();

        // Table of mode/pattern vectors
        for (int k = 0; k < 6; k++) begin
            logic [7:0] cw;
            cw = 8'h80 | (8'(VEC[k][19]) << 3) | (8'(VEC[k][18]) << 2) | 8'(VEC[k][17:16]);
            sck = VEC[k][19];
            ss_n = 1'b1;
            cpu_write(A_CTRL, cw);
            tick(6);
            cpu_read(A_CTRL, rd); chk("R2 ctrl readback", rd, cw);
            clear_flags();
            cpu_write(A_DATA, VEC[k][15:8]);
            xfer(VEC[k][19], VEC[k][18], VEC[k][7:0], 1'b1, 1'b1, 8, -1, 8'h00, mi);
            chk("R3 master receives preload", mi, VEC[k][15:8]);
            chk("R11 irq follows done", irq, 1'b1);
            cpu_read(A_STAT, rd); chk("R3 done flag only", rd, 8'h80);
            cpu_read(A_DATA, rd); chk("R3 slave receives", rd, VEC[k][7:0]);
            chk("R11 irq clears with done", irq, 1'b0);
        end

        // R6: collision mid-character
        cpu_write(A_CTRL, 8'h84);
        sck = 1'b0; ss_n = 1'b1;
        tick(6);
        clear_flags();
        cpu_write(A_DATA, 8'hC4);
        xfer(1'b0, 1'b1, 8'h11, 1'b1, 1'b1, 8, 4, 8'hEE, mi);
        chk("R6 outgoing unaffected", mi, 8'hC4);
        cpu_read(A_STAT, rd); chk("R6 collision and done", rd, 8'hC0);
        cpu_read(A_DATA, rd); chk("R6 rx intact", rd, 8'h11);
        cpu_read(A_STAT, rd); chk("R9 both flags cleared", rd, 8'h00);
        xfer(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8, -1, 8'h00, mi);
        chk("R6 collided write discarded", mi, 8'hC4);
        clear_flags();
        cpu_write(A_DATA, 8'h5C);
        tick(2);
        cpu_read(A_STAT, rd); chk("R6 write outside character", rd, 8'h00);

        // R5: back-to-back phase-1 characters, select held low
        cpu_write(A_DATA, 8'h12);
        xfer(1'b0, 1'b1, 8'hAB, 1'b1, 1'b0, 8, -1, 8'h00, mi);
        chk("R5 first char tx", mi, 8'h12);
        cpu_read(A_STAT, rd); chk("R5 first char done", rd, 8'h80);
        cpu_read(A_DATA, rd); chk("R5 first char rx", rd, 8'hAB);
        cpu_write(A_DATA, 8'h34);
        xfer(1'b0, 1'b1, 8'hCD, 1'b0, 1'b1, 8, -1, 8'h00, mi);
        chk("R5 second char tx", mi, 8'h34);
        cpu_read(A_STAT, rd); chk("R5 second char no collision", rd, 8'h80);
        cpu_read(A_DATA, rd); chk("R5 second char rx", rd, 8'hCD);

        // R4: phase 0 needs select to rise between characters
        cpu_write(A_CTRL, 8'h80);
        tick(6);
        cpu_write(A_DATA, 8'h77);
        xfer(1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 8, -1, 8'h00, mi);
        chk("R4 MSB-first tx", mi, 8'h77);
        clear_flags();
        xfer(1'b0, 1'b0, 8'h22, 1'b0, 1'b1, 8, -1, 8'h00, mi);
        cpu_read(A_STAT, rd); chk("R4 no char without select fall", rd, 8'h00);
        cpu_read(A_DATA, rd); chk("R4 rx unchanged", rd, 8'h55);
        xfer(1'b0, 1'b0, 8'h99, 1'b1, 1'b1, 8, -1, 8'h00, mi);

        // R9: data access without status read keeps flags
        cpu_read(A_DATA, rd); chk("R4 rx after new select fall", rd, 8'h99);
        cpu_read(A_STAT, rd); chk("R9 flag survives lone data read", rd, 8'h80);
        cpu_read(A_DATA, rd);
        cpu_read(A_STAT, rd); chk("R9 cleared by status then data", rd, 8'h00);
        chk("R11 irq low after clear", irq, 1'b0);

        // R10: select rise mid-character abandons it
        cpu_write(A_CTRL, 8'h84);
        tick(6);
        cpu_write(A_DATA, 8'hE1);
        xfer(1'b0, 1'b1, 8'hF0, 1'b1, 1'b1, 3, -1, 8'h00, mi);
        chk("R10 miso_oe after abort", miso_oe, 1'b0);
        cpu_read(A_STAT, rd); chk("R10 no done on abort", rd, 8'h00);
        xfer(1'b0, 1'b1, 8'h3A, 1'b1, 1'b1, 8, -1, 8'h00, mi);
        chk("R10 restart from MSB tx", mi, 8'hE1);
        cpu_read(A_STAT, rd);
        cpu_read(A_DATA, rd); chk("R10 restart from MSB rx", rd, 8'h3A);

        // R10: disabled port with select low
        cpu_write(A_CTRL, 8'h04);
        ss_n = 1'b0;
        tick(6);
        chk("R10 miso_oe when disabled", miso_oe, 1'b0);
        xfer(1'b0, 1'b1, 8'h44, 1'b0, 1'b1, 8, -1, 8'h00, mi);
        cpu_read(A_STAT, rd); chk("R10 disabled port ignores clock", rd, 8'h00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule